// File: doc/BRIEF.md
# Fractional Reference Clock Generator Bank

The block holds four reference-clock channels behind one 32-bit control word. Each channel runs from the fast source clock and turns it into a stream of single-cycle enable pulses. Over time the pulse rate is the source rate multiplied by 18 and divided by that channel's 6-bit fraction value, so the rate lies between about half the source rate and the full source rate. Each channel also has a gate that stops it, and a run output that shows whether the channel is active.

Software reaches the control word through a small memory-mapped port that carries an address, write data, a write strobe and read data. The control word has three write views. A plain write replaces the word. A set write ORs bits into it. A clear write removes bits from it. Because of the set and clear views, one channel can be started or stopped without a read-modify-write that might disturb the other three channels. Read data always shows the control word.

Each channel's rate generator is an accumulator stepped by 18 on every source cycle. When the sum reaches the channel's fraction value, the generator subtracts that value and emits a pulse. Fraction values outside the legal range are clamped inside the hardware. A new fraction value is picked up only at a pulse boundary or while the channel is gated.

Top module: `frcg_bank`

## Requirements
- R1: After reset, `bus_rdata` reads 0x80808080, `ch_run` is 0 and `ch_tick` is 0.
- R2: A write with `bus_addr` = 0 (plain view) replaces the whole control word. The new value appears on `bus_rdata` in the cycle after the write edge.
- R3: A write with `bus_addr` = 1 (set view) makes the control word equal to the old word OR `bus_wdata`.
- R4: A write with `bus_addr` = 2 (clear view) makes the control word equal to the old word AND NOT `bus_wdata`.
- R5: Channel n uses bits 8n+7..8n of the control word, and bit 8n+7 is its gate. While the gate is 1, `ch_run[n]` is 0 and `ch_tick[n]` stays 0 from the next cycle on. While the gate is 0, `ch_run[n]` is 1.
- R6: Channel n's fraction value F sits in bits 8n+5..8n. After a channel is ungated with F in 18..35, exactly 18·k pulses appear on `ch_tick[n]` in the first F·k cycles after the ungating edge. This holds for every F from 18 to 35.
- R7: A fraction value below 18, including 0, behaves as 18, so a pulse appears on every cycle. A fraction value above 35 behaves as 35.
- R8: A running channel never goes two consecutive cycles without a pulse.
- R9: A write with `bus_addr` = 3 leaves the control word unchanged.
- R10: A change to the fraction value of a running channel takes effect only after the next pulse. For example, ungate the channel at F=20, then write F=35 on the following edge. The pulses seen after edges +2..+6 from ungating are then 1,0,1,1,0.
- R11: Gating a channel clears its accumulator. Each new ungating therefore starts from zero phase, and R6 holds again for that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Write view: 0 plain, 1 set, 2 clear, 3 none |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle that it is high |
| bus_rdata | output | 32 | Current control word |
| ch_run | output | 4 | Channel active (gate bit clear), one bit per channel |
| ch_tick | output | 4 | One-cycle rate enable pulses, one bit per channel |

## Verification
The bus checks assume that the write port has no back-pressure: every cycle in which `bus_we` is high is one complete write, and read data is not sampled in the same cycle. The bench drives every write for exactly one cycle from the falling edge and then drops the strobe. The rate and fraction-hold checks assume that a fraction value changes only through a register write. For the exact pulse counts in R6, the bench first writes the fraction value with the gate set and only then clears the gate with a clear-view write. Every counting window therefore starts from zero phase.

// File: rtl/frcg_pkg.sv
package frcg_pkg;
  localparam int NUM_CH     = 4;
  localparam int LANE_W     = 8;
  localparam int FRAC_W     = 6;
  localparam int GATE_POS   = 7;
  localparam int RATE_NUMER = 18;
  localparam int FRAC_MIN   = 18;
  localparam int FRAC_MAX   = 35;
  localparam int REG_W      = NUM_CH * LANE_W;
  localparam int ADDR_W     = 2;
  localparam int ACC_W      = $clog2(FRAC_MAX + RATE_NUMER + 1);
  localparam logic [LANE_W-1:0] LANE_RESET = LANE_W'(1) << GATE_POS;

  typedef enum logic [ADDR_W-1:0] {
    VIEW_PLAIN = 2'd0,
    VIEW_SET   = 2'd1,
    VIEW_CLEAR = 2'd2,
    VIEW_NONE  = 2'd3
  } view_e;

  function automatic logic [FRAC_W-1:0] frac_clamp(input logic [FRAC_W-1:0] f);
    if (int'(f) < FRAC_MIN)      return FRAC_W'(FRAC_MIN);
    else if (int'(f) > FRAC_MAX) return FRAC_W'(FRAC_MAX);
    else                         return f;
  endfunction
endpackage

// File: rtl/frcg_ctrl_reg.sv
module frcg_ctrl_reg
  import frcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              we,
  output logic [REG_W-1:0]  word
);
  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (we) begin
      unique case (view_e'(addr))
        VIEW_PLAIN: word_d = wdata;
        VIEW_SET:   word_d = word_q | wdata;
        VIEW_CLEAR: word_d = word_q & ~wdata;
        default:    word_d = word_q;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) word_q[n*LANE_W +: LANE_W] <= LANE_RESET;
      else        word_q[n*LANE_W +: LANE_W] <= word_d[n*LANE_W +: LANE_W];
    end
  end

  assign word = word_q;
endmodule

// File: rtl/frcg_rate_gen.sv
module frcg_rate_gen
  import frcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FRAC_W-1:0] frac_req,
  output logic              tick,
  output logic [FRAC_W-1:0] frac_cur
);
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  sum;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] frac_eff;
  logic              tick_q;
  logic              hit;

  assign frac_eff = frac_clamp(frac_req);
  assign sum      = acc_q + ACC_W'(RATE_NUMER);
  assign hit      = sum >= ACC_W'(frac_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
      frac_q <= FRAC_W'(FRAC_MIN);
    end else if (!run) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
      frac_q <= frac_eff;
    end else if (hit) begin
      acc_q  <= sum - ACC_W'(frac_q);
      tick_q <= 1'b1;
      frac_q <= frac_eff;
    end else begin
      acc_q  <= sum;
      tick_q <= 1'b0;
    end
  end

  assign tick     = tick_q;
  assign frac_cur = frac_q;
endmodule

// File: rtl/frcg_bank.sv
module frcg_bank
  import frcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] ch_run,
  output logic [NUM_CH-1:0] ch_tick
);
  logic [REG_W-1:0]         ctrl_word;
  logic [NUM_CH*FRAC_W-1:0] frac_cur_flat;

  frcg_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .we    (bus_we),
    .word  (ctrl_word)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [LANE_W-1:0] lane;
    assign lane      = ctrl_word[n*LANE_W +: LANE_W];
    assign ch_run[n] = ~lane[GATE_POS];

    frcg_rate_gen u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ch_run[n]),
      .frac_req (lane[FRAC_W-1:0]),
      .tick     (ch_tick[n]),
      .frac_cur (frac_cur_flat[n*FRAC_W +: FRAC_W])
    );
  end

  assign bus_rdata = ctrl_word;
endmodule

// File: rtl/frcg_bank_chk.sv
module frcg_bank_chk
  import frcg_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [REG_W-1:0]         bus_wdata,
  input logic                     bus_we,
  input logic [REG_W-1:0]         bus_rdata,
  input logic [NUM_CH-1:0]        ch_run,
  input logic [NUM_CH-1:0]        ch_tick,
  input logic [NUM_CH*FRAC_W-1:0] frac_cur
);
  p_plain_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd0 |=> bus_rdata == $past(bus_wdata));

  p_set_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd1 |=> bus_rdata == ($past(bus_rdata) | $past(bus_wdata)));

  p_clear_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd2 |=> bus_rdata == ($past(bus_rdata) & ~$past(bus_wdata)));

  p_no_view_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 2'd3 |=> $stable(bus_rdata));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(bus_rdata));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    p_gate_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[n] |=> !ch_tick[n]);

    p_run_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[n] == !bus_rdata[n*LANE_W + GATE_POS]);

    p_min_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_run[n], 2) && $past(ch_run[n]) && ch_run[n] && !$past(ch_tick[n])
      |-> ch_tick[n]);

    p_frac_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(frac_cur[n*FRAC_W +: FRAC_W]) >= FRAC_MIN &&
      int'(frac_cur[n*FRAC_W +: FRAC_W]) <= FRAC_MAX);

    p_frac_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_run[n]) && !ch_tick[n] |-> $stable(frac_cur[n*FRAC_W +: FRAC_W]));
  end
endmodule

bind frcg_bank frcg_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .ch_run    (ch_run),
  .ch_tick   (ch_tick),
  .frac_cur  (frac_cur_flat)
);

// File: tb/frcg_bank_bench.sv
module frcg_bank_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  ch_run;
  logic [3:0]  ch_tick;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frcg_bank u_frcg_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ch_run(ch_run), .ch_tick(ch_tick)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // driver side: push expected value
  task automatic expect_val(input string tag, input int v);
    tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  // monitor side: pop and compare against observed
  task automatic observe(input int act);
    string t;
    int e;
    t = tag_q.pop_front();
    e = exp_q.pop_front();
    checks++;
    if (act != e) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, e);
    end
  endtask

  // called just after a falling edge; write lasts one cycle
  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  // ungate channel c at fraction f and count pulses over n cycles
  task automatic run_rate(input string tag, input int c, input int f, input int n, input int exp);
    logic [31:0] w;
    int cnt;
    int others;
    int run_ok;
    w = 32'h80808080;
    w[c*8 +: 8] = 8'h80 | 8'(f);
    bus_wr(2'd0, w);
    bus_wr(2'd2, 32'h1 << (c*8 + 7));
    cnt = 0; others = 0; run_ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt += int'(ch_tick[c]);
      others += $countones(ch_tick & ~(4'b1 << c));
      if (ch_run != (4'b1 << c)) run_ok = 0;
    end
    expect_val(tag, exp);
    observe(cnt);
    expect_val("R5 other channels silent", 0);
    observe(others);
    expect_val("R5 run output matches gate", 1);
    observe(run_ok);
    bus_wr(2'd1, 32'h1 << (c*8 + 7));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    expect_val("R1 reset word", 32'h80808080); observe(int'(bus_rdata));
    expect_val("R1 reset run", 0);             observe(int'(ch_run));
    expect_val("R1 reset tick", 0);            observe(int'(ch_tick));

    bus_wr(2'd0, 32'h12345678);
    expect_val("R2 plain write", 32'h12345678); observe(int'(bus_rdata));
    bus_wr(2'd1, 32'h80808080);
    expect_val("R3 set view", 32'h92B4D6F8);    observe(int'(bus_rdata));
    bus_wr(2'd2, 32'h0000F0F0);
    expect_val("R4 clear view", 32'h92B40608);  observe(int'(bus_rdata));
    bus_wr(2'd3, 32'hFFFFFFFF);
    expect_val("R9 no-view write", 32'h92B40608); observe(int'(bus_rdata));
    expect_val("R5 run from gates", 4'b0011);   observe(int'(ch_run));

    bus_wr(2'd0, 32'h80808080);
    expect_val("R5 run cleared", 0);            observe(int'(ch_run));
    repeat (2) @(negedge clk);
    expect_val("R5 ticks stop when gated", 0);  observe(int'(ch_tick));

    for (int f = 18; f <= 35; f++)
      run_rate($sformatf("R6 count f=%0d", f), f % 4, f, f * 2, 36);

    run_rate("R11 restart phase f=27", 1, 27, 27 * 3, 54);
    run_rate("R7 clamp f=0", 2, 0, 36, 36);
    run_rate("R7 clamp f=10", 3, 10, 36, 36);
    run_rate("R7 clamp f=63", 0, 63, 70, 36);

    // R10: ungate at 20, switch to 35 on the next edge
    bus_wr(2'd0, 32'h80808094);
    bus_wr(2'd2, 32'h00000080);
    bus_wr(2'd0, 32'h80808023);
    expect_val("R10 tick edge+1", 0); observe(int'(ch_tick[0]));
    begin
      int pat[5] = '{1, 0, 1, 1, 0};
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        expect_val($sformatf("R10 tick edge+%0d", i + 2), pat[i]);
        observe(int'(ch_tick[0]));
      end
    end
    bus_wr(2'd1, 32'h00000080);

    summary();
    $finish;
  end
endmodule